// File: doc/BRIEF.md
# Indirect Flash Read Engine

This block moves a programmed number of bytes from a serial flash into an on-chip byte FIFO. Software sets up the transfer through a small word-addressed register port: a flash start address, a byte count, a trigger window base, a window size code and an optional watermark. Writing the start bit begins the transfer. The engine then requests bytes one at a time from an abstracted flash byte stream, which carries an address, a request and an acknowledge. Each acknowledged byte is pushed into the FIFO.

The host drains the FIFO with plain reads. A read from any address inside the trigger window pops one byte. Software can time those reads in two ways: by polling the fill level register, or by waiting for the watermark interrupt. The watermark interrupt fires when the fill level climbs past the programmed level. It also fires when the last byte of the transfer lands in the FIFO, even if the level is lower than the watermark. A done flag and a completion interrupt mark the end of the transfer, which is when every byte has been both fetched and read out.

Top module: `ind_rd_engine`

## Requirements
- R1: After reset the engine is idle. The control register (word 0) reads 0, the fill level (word 6) reads 0, and both interrupt outputs are low.
- R2: Writing a 1 to bit 0 of word 0 while idle starts a transfer. Bit 0 always reads 0, and bit 1 of word 0 reads 1 while the transfer is busy.
- R3: The engine requests exactly the number of bytes in word 2. The requests start at the flash address in word 1 and step by one. Bytes are buffered in that order, and no request is made once the count is used up.
- R4: The FIFO holds DEPTH bytes. Flash requests stop while the FIFO is full and resume once the host frees space, with no byte lost or duplicated.
- R5: The window base is in word 3 and the size code R is in word 4. A host read at an address from base to base+2^R-1 pops one byte and returns it. A read outside the window returns 0 and leaves the fill level unchanged.
- R6: A window read while the FIFO is empty returns 0 and sets the sticky underflow flag, bit 2 of word 7.
- R7: Word 6 reads the current FIFO fill level, and the level never exceeds DEPTH.
- R8: The watermark is in word 5. When it is nonzero, a byte push that takes the fill level above the watermark sets bit 0 of word 7 and drives irq_wm.
- R9: When the watermark is nonzero, pushing the final byte of a transfer sets the watermark flag even if the level stays below the watermark. A watermark of 0 never sets the flag.
- R10: Bit 5 of word 0 (done) becomes 1 only after every byte has been fetched and popped. The same event sets completion flag bit 1 of word 7 and drives irq_done. Done and busy are never both 1.
- R11: Bits of word 7 are sticky, and writing 1 to a bit clears it.
- R12: A start write while busy is ignored. The running transfer keeps its original flash address and byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fl_req | output | 1 | Flash byte request |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_ack | input | 1 | Flash byte delivered this cycle |
| fl_data | input | DATA_W | Flash byte |
| hr_en | input | 1 | Host read strobe |
| hr_addr | input | ADDR_W | Host read address |
| hr_data | output | DATA_W | Host read data (combinational) |
| irq_wm | output | 1 | Watermark interrupt (sticky) |
| irq_done | output | 1 | Completion interrupt (sticky) |

## Verification
The assertions assume three things about the inputs. The flash acknowledge means something only while a request is up. The trigger window does not wrap past the top of the address space. Configuration is not rewritten in a way that moves the window while a read is in flight. The bench's flash model presents data for whatever address is requested and gates its acknowledge with its own enable. It programs only windows well below the address limit, and it paces the acknowledges per cycle to walk the fill level through the watermark boundary.

// File: rtl/ire_pkg.sv
package ire_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_FADDR  = 3'd1,
    RA_COUNT  = 3'd2,
    RA_TBASE  = 3'd3,
    RA_TRANGE = 3'd4,
    RA_WMARK  = 3'd5,
    RA_FILL   = 3'd6,
    RA_IRQ    = 3'd7
  } reg_idx_e;

  localparam int CTRL_START = 0;
  localparam int CTRL_BUSY  = 1;
  localparam int CTRL_DONE  = 5;

  localparam int IRQ_WM   = 0;
  localparam int IRQ_CMPL = 1;
  localparam int IRQ_UFL  = 2;
endpackage

// File: rtl/ire_fifo.sv
module ire_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              empty,
  output logic [LVL_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;

  assign full  = (cnt_q == LVL_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign level = cnt_q;
  assign dout  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + 1'b1;
    if (pop)  rp_d = rp_q + 1'b1;
    cnt_d = cnt_q + LVL_W'(push) - LVL_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ire_fetch.sv
module ire_fetch #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              stall,
  input  logic              fl_ack,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              push,
  output logic              last
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;

  assign fl_req  = (rem_q != '0) && !stall;
  assign fl_addr = addr_q;
  assign push    = fl_req && fl_ack;
  assign last    = push && (rem_q == CNT_W'(1));

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (start) begin
      addr_d = start_addr;
      rem_d  = count;
    end else if (push) begin
      addr_d = addr_q + 1'b1;
      rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/ire_regs.sv
module ire_regs
  import ire_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              push,
  input  logic              pop,
  input  logic              last_byte,
  input  logic              underflow,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  lvl_next,
  output logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] faddr,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] tbase,
  output logic [4:0]        trange,
  output logic [2:0]        stat
);
  logic [ADDR_W-1:0] faddr_q, tbase_q;
  logic [CNT_W-1:0]  count_q, wm_q, drain_q, drain_d;
  logic [4:0]        trange_q;
  logic              busy_q, busy_d, done_q, done_d;
  logic [2:0]        stat_q, stat_d;
  logic              wr_faddr, wr_count, wr_tbase, wr_trange, wr_wm, wr_irq;
  logic              finish, wm_evt;

  assign wr_faddr  = reg_we && (reg_addr == RA_FADDR);
  assign wr_count  = reg_we && (reg_addr == RA_COUNT);
  assign wr_tbase  = reg_we && (reg_addr == RA_TBASE);
  assign wr_trange = reg_we && (reg_addr == RA_TRANGE);
  assign wr_wm     = reg_we && (reg_addr == RA_WMARK);
  assign wr_irq    = reg_we && (reg_addr == RA_IRQ);

  assign start  = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CTRL_START] && !busy_q;
  assign finish = busy_q && ((drain_q == '0) || (pop && drain_q == CNT_W'(1)));
  assign wm_evt = push && (wm_q != '0) && ((CNT_W'(lvl_next) > wm_q) || last_byte);

  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    drain_d = drain_q;
    if (start) begin
      busy_d  = 1'b1;
      done_d  = 1'b0;
      drain_d = count_q;
    end else if (finish) begin
      busy_d  = 1'b0;
      done_d  = 1'b1;
      drain_d = '0;
    end else if (busy_q && pop) begin
      drain_d = drain_q - 1'b1;
    end
    stat_d = stat_q & ~(wr_irq ? reg_wdata[2:0] : 3'b000);
    if (wm_evt)    stat_d[IRQ_WM]   = 1'b1;
    if (finish)    stat_d[IRQ_CMPL] = 1'b1;
    if (underflow) stat_d[IRQ_UFL]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q  <= '0;
      count_q  <= '0;
      tbase_q  <= '0;
      trange_q <= '0;
      wm_q     <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      drain_q  <= '0;
      stat_q   <= '0;
    end else begin
      if (wr_faddr)  faddr_q  <= reg_wdata[ADDR_W-1:0];
      if (wr_count)  count_q  <= reg_wdata[CNT_W-1:0];
      if (wr_tbase)  tbase_q  <= reg_wdata[ADDR_W-1:0];
      if (wr_trange) trange_q <= reg_wdata[4:0];
      if (wr_wm)     wm_q     <= reg_wdata[CNT_W-1:0];
      busy_q  <= busy_d;
      done_q  <= done_d;
      drain_q <= drain_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CTRL_BUSY] = busy_q;
        reg_rdata[CTRL_DONE] = done_q;
      end
      RA_FADDR:  reg_rdata = REG_W'(faddr_q);
      RA_COUNT:  reg_rdata = REG_W'(count_q);
      RA_TBASE:  reg_rdata = REG_W'(tbase_q);
      RA_TRANGE: reg_rdata = REG_W'(trange_q);
      RA_WMARK:  reg_rdata = REG_W'(wm_q);
      RA_FILL:   reg_rdata = REG_W'(level);
      RA_IRQ:    reg_rdata = REG_W'(stat_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign faddr  = faddr_q;
  assign count  = count_q;
  assign tbase  = tbase_q;
  assign trange = trange_q;
  assign stat   = stat_q;
endmodule

// File: rtl/ind_rd_engine.sv
module ind_rd_engine
  import ire_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_ack,
  input  logic [DATA_W-1:0] fl_data,
  input  logic              hr_en,
  input  logic [ADDR_W-1:0] hr_addr,
  output logic [DATA_W-1:0] hr_data,
  output logic              irq_wm,
  output logic              irq_done
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic              push, pop, last, full, empty, hit, uflow;
  logic              start, busy, done;
  logic [LVL_W-1:0]  level, lvl_next;
  logic [DATA_W-1:0] head;
  logic [ADDR_W-1:0] cfg_faddr, cfg_tbase, win_off;
  logic [CNT_W-1:0]  cfg_count;
  logic [4:0]        cfg_trange;
  logic [2:0]        stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign win_off  = hr_addr - cfg_tbase;
  assign hit      = hr_en && ((win_off >> cfg_trange) == '0);
  assign pop      = hit && !empty;
  assign uflow    = hit && empty;
  assign hr_data  = pop ? head : '0;
  assign lvl_next = level + LVL_W'(push) - LVL_W'(pop);
  assign irq_wm   = stat[IRQ_WM];
  assign irq_done = stat[IRQ_CMPL];

  ire_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .push(push), .din(fl_data), .pop(pop),
    .dout(head), .full(full), .empty(empty), .level(level)
  );

  ire_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_i_n), .start(start), .start_addr(cfg_faddr),
    .count(cfg_count), .stall(full), .fl_ack(fl_ack), .fl_req(fl_req),
    .fl_addr(fl_addr), .push(push), .last(last)
  );

  ire_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push(push), .pop(pop),
    .last_byte(last), .underflow(uflow), .level(level), .lvl_next(lvl_next),
    .start(start), .busy(busy), .done(done), .faddr(cfg_faddr),
    .count(cfg_count), .tbase(cfg_tbase), .trange(cfg_trange), .stat(stat)
  );
endmodule

// File: rtl/ire_checker.sv
module ire_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_req,
  input logic              full,
  input logic              hit,
  input logic              empty,
  input logic [DATA_W-1:0] hr_data,
  input logic [LVL_W-1:0]  level,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              irq_done,
  input logic              ufl_flag
);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !fl_req);

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && empty) |-> (hr_data == '0));

  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && empty) |=> ufl_flag);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));

  assert_idle_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fl_req);

  assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> irq_done);
endmodule

bind ind_rd_engine ire_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_i_n), .fl_req(fl_req), .full(full), .hit(hit),
  .empty(empty), .hr_data(hr_data), .level(level), .start(start),
  .busy(busy), .done(done), .irq_done(irq_done), .ufl_flag(stat[2])
);

// File: tb/tb_ind_rd_engine.sv
module tb_ind_rd_engine;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic              clk, rst_n, reg_we, fl_req, fl_ack, hr_en, irq_wm, irq_done;
  logic [2:0]        reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic [ADDR_W-1:0] fl_addr, hr_addr;
  logic [DATA_W-1:0] fl_data, hr_data;
  logic              ack_en;
  int                n_run, n_fail;

  assign fl_ack  = ack_en;
  assign fl_data = fl_addr[7:0] ^ 8'hA5;

  ind_rd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_req(fl_req),
    .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_data(fl_data), .hr_en(hr_en),
    .hr_addr(hr_addr), .hr_data(hr_data), .irq_wm(irq_wm), .irq_done(irq_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic hread(input logic [31:0] a, output logic [7:0] d);
    @(negedge clk);
    hr_en = 1'b1; hr_addr = a;
    #1 d = hr_data;
    @(posedge clk); #1;
    hr_en = 1'b0;
  endtask

  task automatic ack_pulses(input int n);
    @(negedge clk);
    ack_en = 1'b1;
    repeat (n) @(negedge clk);
    ack_en = 1'b0;
  endtask

  task automatic setup(input logic [31:0] fa, input logic [31:0] cnt,
                       input logic [31:0] rng, input logic [31:0] wm);
    wr(3'd1, fa); wr(3'd2, cnt); wr(3'd3, BASE); wr(3'd4, rng); wr(3'd5, wm);
  endtask

  task automatic test_reset;
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    hr_en = 1'b0; hr_addr = '0; ack_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    rd(3'd0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(3'd6, v); check(v == 0, "R1 fill", v, 0);
    check(!irq_wm && !irq_done, "R1 irq", {irq_wm, irq_done}, 0);
  endtask

  task automatic test_basic;
    logic [31:0] v; logic [7:0] d; logic [31:0] offs [6];
    offs = '{0, 15, 7, 3, 12, 1};
    setup(32'h100, 6, 4, 0);
    ack_en = 1'b1;
    wr(3'd0, 1);
    rd(3'd0, v); check(v[0] == 0 && v[1] == 1, "R2 start bit reads 0 busy 1", v, 2);
    repeat (12) @(posedge clk);
    rd(3'd6, v); check(v == 6, "R7 fill after 6 bytes", v, 6);
    check(!fl_req, "R3 no request past count", fl_req, 0);
    check(!irq_wm, "R9 zero watermark never fires", irq_wm, 0);
    hread(BASE + 16, d); check(d == 0, "R5 outside window data", d, 0);
    rd(3'd6, v); check(v == 6, "R5 outside window no pop", v, 6);
    rd(3'd7, v); check(v[2] == 0, "R5 outside window no underflow", v, 0);
    for (int i = 0; i < 6; i++) begin
      hread(BASE + offs[i], d);
      check(d == ((8'h00 + 8'(i)) ^ 8'hA5), "R3 R5 data order", d, (8'(i)) ^ 8'hA5);
      if (i == 4) begin
        rd(3'd0, v); check(v[5] == 0, "R10 not done before last pop", v, 0);
      end
    end
    rd(3'd0, v); check(v[5] == 1 && v[1] == 0, "R10 done set, busy clear", v, 32'h20);
    rd(3'd7, v); check(v[1] == 1 && irq_done, "R10 completion flag", v, 2);
    wr(3'd7, 32'h2);
    rd(3'd7, v); check(v == 0 && !irq_done, "R11 W1C clears completion", v, 0);
    ack_en = 1'b0;
  endtask

  task automatic test_underflow;
    logic [31:0] v; logic [7:0] d;
    hread(BASE, d); check(d == 0, "R6 empty read data", d, 0);
    rd(3'd7, v); check(v[2] == 1, "R6 underflow flag", v, 4);
    wr(3'd7, 32'h4);
    rd(3'd7, v); check(v == 0, "R11 W1C clears underflow", v, 0);
  endtask

  task automatic test_stall;
    logic [31:0] v; logic [7:0] d;
    setup(32'h40, 20, 3, 0);
    ack_en = 1'b1;
    wr(3'd0, 1);
    repeat (30) @(posedge clk);
    rd(3'd6, v); check(v == DEPTH, "R4 fill stops at depth", v, DEPTH);
    check(!fl_req, "R4 request held while full", fl_req, 0);
    for (int i = 0; i < 20; i++) begin
      hread(BASE + 32'(i % 8), d);
      check(d == ((8'h40 + 8'(i)) ^ 8'hA5), "R4 data across stall", d, (8'h40 + 8'(i)) ^ 8'hA5);
      if (i == 3) begin
        repeat (6) @(posedge clk);
        rd(3'd6, v); check(v == DEPTH, "R4 refills after drain", v, DEPTH);
      end
    end
    rd(3'd0, v); check(v[5] == 1, "R10 done after stalled transfer", v, 32'h20);
    wr(3'd7, 32'h7);
    ack_en = 1'b0;
  endtask

  task automatic test_watermark;
    logic [31:0] v; logic [7:0] d;
    setup(32'h10, 8, 4, 2);
    wr(3'd0, 1);
    ack_pulses(2);
    rd(3'd6, v); check(v == 2, "R7 fill after two bytes", v, 2);
    check(!irq_wm, "R8 level equal to watermark", irq_wm, 0);
    ack_pulses(1);
    rd(3'd6, v); check(v == 3, "R7 fill after three bytes", v, 3);
    check(irq_wm, "R8 level above watermark", irq_wm, 1);
    wr(3'd7, 32'h1);
    check(!irq_wm, "R11 W1C clears watermark", irq_wm, 0);
    ack_en = 1'b1;
    repeat (10) @(posedge clk);
    for (int i = 0; i < 8; i++) hread(BASE + 32'(i), d);
    ack_en = 1'b0;
    wr(3'd7, 32'h7);
    setup(32'h20, 4, 4, 10);
    ack_en = 1'b1;
    wr(3'd0, 1);
    repeat (8) @(posedge clk);
    rd(3'd6, v); check(v == 4, "R9 fill below watermark", v, 4);
    check(irq_wm, "R9 final byte raises watermark", irq_wm, 1);
    for (int i = 0; i < 4; i++) hread(BASE, d);
    ack_en = 1'b0;
    wr(3'd7, 32'h7);
  endtask

  task automatic test_restart;
    logic [31:0] v; logic [7:0] d;
    setup(32'h200, 2, 4, 0);
    wr(3'd0, 1);
    wr(3'd1, 32'h300);
    wr(3'd2, 5);
    wr(3'd0, 1);
    ack_en = 1'b1;
    repeat (8) @(posedge clk);
    ack_en = 1'b0;
    rd(3'd6, v); check(v == 2, "R12 count unchanged by restart", v, 2);
    hread(BASE, d); check(d == (8'h00 ^ 8'hA5), "R12 address unchanged", d, 8'hA5);
    hread(BASE, d); check(d == (8'h01 ^ 8'hA5), "R12 second byte", d, 8'hA4);
    rd(3'd0, v); check(v[5] == 1, "R12 done after original count", v, 32'h20);
    wr(3'd7, 32'h7);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    test_reset;
    test_basic;
    test_underflow;
    test_stall;
    test_watermark;
    test_restart;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule